// File: doc/BRIEF.md
# Dot Clock PLL Parameter Search

This block picks the three configuration bytes of a fractional-free dot clock PLL for a requested pixel frequency. It takes the frequency in hertz and first checks it against the legal window. Targets outside the window are answered at once with an error result. A legal target is doubled until it reaches the VCO floor, and each doubling is counted into the post-divide field. The engine then tries every reference divider n in turn, one per clock. For each n it derives the largest feedback multiplier m whose product does not exceed the scaled target, and it scores the candidate by the exact frequency error. The best candidate is encoded into bytes that a register writer can use directly.

Requests enter on a valid/ready port. `in_ready` is high only while the engine is idle, so a request is taken on the clock edge where `in_valid` and `in_ready` are both high. Results leave on a valid/ready port. When `out_valid` is high and `out_ready` is low, the result and its valid stay frozen. The engine accepts no new request until the result has been taken.

Top module: `dotclk_pll_search`

## Requirements
- R1: After reset, `out_valid` is 0, `busy` is 0 and `in_ready` is 1.
- R2: A target above 220,000,000 or below 3,125,000 gives a result with `out_err`=1 and `out_m`, `out_n` and `out_div` all 0. This result appears on the edge right after acceptance, with no search. Both limits themselves are legal.
- R3: A legal target is doubled while it is below 100,000,000. `out_div[7:4]` holds the number of doublings (0 to 5), and `out_div[3]` and `out_div[1:0]` are 0.
- R4: With reference R = 14,318,180 and scaled target F, n runs from 3 to 257. The multiplier is m = floor(n·F/R). When 3 ≤ m ≤ 257, the error is |n·F − R·m|.
- R5: When 258 ≤ m ≤ 1028, the error is |n·F − R·(m with bits [1:0] cleared)|. Candidates with m > 1028 are skipped.
- R6: A candidate replaces the best one only when its error is strictly smaller, so on a tie the lowest n wins.
- R7: `out_n` = best n − 2. If best m > 257, then `out_m` = (m>>2) − 2 and `out_div[2]` = 0. Otherwise `out_m` = m − 2 and `out_div[2]` = 1. `out_err` is 0.
- R8: For a legal target that needs k doublings, `out_valid` rises k+257 edges after the accepting edge.
- R9: `in_ready` is low and `busy` is high from acceptance until the result is taken. An `in_valid` seen in that time is ignored and produces no further result.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and all result fields hold. On the edge where both are high, the engine returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Engine idle, request can be taken |
| in_freq | input | 32 | Target frequency in Hz |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_m | output | 8 | Feedback multiplier byte |
| out_n | output | 8 | Reference divider byte |
| out_div | output | 8 | Post-divide field [7:4], loop-divide-by-one bit [2] |
| out_err | output | 1 | Target out of range |
| busy | output | 1 | Request in progress or result pending |

## Verification
A wrong scaling count or a stuck doubling register shows up in two places: `out_div[7:4]` and the result latency. Both are visible on the first result. A corrupted best-candidate register, a wrong comparison (not strict) or a wrong truncation in the wide regime shows up only in `out_m`/`out_n`. These faults are exposed by targets whose answer is known in advance, such as an exact multiple of the reference where two n tie, and by a wide-regime target. A wrong ready/valid state shows up within one or two cycles as a lost, duplicated or changing result.

// File: rtl/pllsrch_pkg.sv
`timescale 1ns/1ps
package pllsrch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SCALE  = 3'd1,
    ST_SEARCH = 3'd2,
    ST_ENCODE = 3'd3,
    ST_DONE   = 3'd4
  } state_e;
endpackage

// File: rtl/pllsrch_candidate.sv
`timescale 1ns/1ps
// Scores one reference divider against the scaled target.
module pllsrch_candidate #(
  parameter int unsigned FW         = 32,
  parameter int unsigned NW         = 9,
  parameter int unsigned MW         = 11,
  parameter int unsigned PW         = 48,
  parameter int unsigned REF_HZ     = 14318180,
  parameter int unsigned M_LO       = 3,
  parameter int unsigned M_HI       = 257,
  parameter int unsigned M_WIDE_HI  = 1028
) (
  input  logic [FW-1:0] ftgt,
  input  logic [NW-1:0] n,
  output logic          ok,
  output logic [MW-1:0] m,
  output logic [PW-1:0] err
);
  localparam logic [PW-1:0] REF_W = PW'(REF_HZ);
  localparam logic [PW-1:0] LO_W  = PW'(M_LO);
  localparam logic [PW-1:0] HI_W  = PW'(M_HI);
  localparam logic [PW-1:0] WHI_W = PW'(M_WIDE_HI);

  logic [PW-1:0] prod_t, m_full, m_eff, prod_r;

  always_comb begin
    prod_t = PW'(ftgt) * PW'(n);
    m_full = prod_t / REF_W;
    ok     = 1'b0;
    m_eff  = m_full;
    if (m_full >= LO_W && m_full <= HI_W) begin
      ok = 1'b1;
    end else if (m_full > HI_W && m_full <= WHI_W) begin
      ok    = 1'b1;
      m_eff = m_full & ~PW'(3);
    end
    prod_r = m_eff * REF_W;
    err    = (prod_t >= prod_r) ? (prod_t - prod_r) : (prod_r - prod_t);
    m      = MW'(m_full);
  end
endmodule

// File: rtl/pllsrch_best.sv
`timescale 1ns/1ps
// Holds the lowest-error candidate seen since the last clear.
module pllsrch_best #(
  parameter int unsigned NW = 9,
  parameter int unsigned MW = 11,
  parameter int unsigned PW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          cand_valid,
  input  logic [NW-1:0] cand_n,
  input  logic [MW-1:0] cand_m,
  input  logic [PW-1:0] cand_err,
  output logic [NW-1:0] best_n,
  output logic [MW-1:0] best_m
);
  logic [PW-1:0] best_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_err <= '1;
      best_n   <= '0;
      best_m   <= '0;
    end else if (clear) begin
      best_err <= '1;
      best_n   <= '0;
      best_m   <= '0;
    end else if (cand_valid && cand_err < best_err) begin
      best_err <= cand_err;
      best_n   <= cand_n;
      best_m   <= cand_m;
    end
  end
endmodule

// File: rtl/pllsrch_encode.sv
`timescale 1ns/1ps
// Turns the winning pair into register bytes.
module pllsrch_encode #(
  parameter int unsigned NW   = 9,
  parameter int unsigned MW   = 11,
  parameter int unsigned SW   = 4,
  parameter int unsigned M_HI = 257
) (
  input  logic [NW-1:0] best_n,
  input  logic [MW-1:0] best_m,
  input  logic [SW-1:0] post,
  output logic [7:0]    m_byte,
  output logic [7:0]    n_byte,
  output logic [7:0]    div_byte
);
  logic          wide;
  logic [MW-1:0] m_sel;

  always_comb begin
    wide     = best_m > MW'(M_HI);
    m_sel    = wide ? (best_m >> 2) : best_m;
    m_byte   = 8'(m_sel - MW'(2));
    n_byte   = 8'(best_n - NW'(2));
    div_byte = 8'({post, 1'b0, ~wide, 2'b00});
  end
endmodule

// File: rtl/dotclk_pll_search.sv
`timescale 1ns/1ps
module dotclk_pll_search #(
  parameter int unsigned FW           = 32,
  parameter int unsigned REF_HZ       = 14318180,
  parameter int unsigned MAX_HZ       = 220000000,
  parameter int unsigned MIN_HZ       = 3125000,
  parameter int unsigned VCO_FLOOR_HZ = 100000000,
  parameter int unsigned N_FIRST      = 3,
  parameter int unsigned N_LAST       = 257,
  parameter int unsigned M_LO         = 3,
  parameter int unsigned M_HI         = 257,
  parameter int unsigned M_WIDE_HI    = 1028,
  parameter int unsigned PW           = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [FW-1:0] in_freq,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_m,
  output logic [7:0]    out_n,
  output logic [7:0]    out_div,
  output logic          out_err,
  output logic          busy
);
  import pllsrch_pkg::*;

  localparam int unsigned NW = $clog2(N_LAST + 1);
  localparam int unsigned MW = $clog2(M_WIDE_HI + 1);
  localparam int unsigned SW = 4;

  state_e        state_q;
  logic [FW-1:0] ftgt_q;
  logic [SW-1:0] post_q;
  logic [NW-1:0] n_q;
  logic [7:0]    res_m_q, res_n_q, res_div_q;
  logic          res_err_q;

  logic          in_bad;
  logic          cand_ok;
  logic [MW-1:0] cand_m;
  logic [PW-1:0] cand_err;
  logic [NW-1:0] best_n;
  logic [MW-1:0] best_m;
  logic [7:0]    enc_m, enc_n, enc_div;

  assign in_bad = (in_freq > FW'(MAX_HZ)) || (in_freq < FW'(MIN_HZ));

  pllsrch_candidate #(
    .FW(FW), .NW(NW), .MW(MW), .PW(PW), .REF_HZ(REF_HZ),
    .M_LO(M_LO), .M_HI(M_HI), .M_WIDE_HI(M_WIDE_HI)
  ) u_cand (
    .ftgt(ftgt_q), .n(n_q), .ok(cand_ok), .m(cand_m), .err(cand_err)
  );

  pllsrch_best #(.NW(NW), .MW(MW), .PW(PW)) u_best (
    .clk(clk), .rst_n(rst_n),
    .clear(state_q == ST_SCALE),
    .cand_valid((state_q == ST_SEARCH) && cand_ok),
    .cand_n(n_q), .cand_m(cand_m), .cand_err(cand_err),
    .best_n(best_n), .best_m(best_m)
  );

  pllsrch_encode #(.NW(NW), .MW(MW), .SW(SW), .M_HI(M_HI)) u_enc (
    .best_n(best_n), .best_m(best_m), .post(post_q),
    .m_byte(enc_m), .n_byte(enc_n), .div_byte(enc_div)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ftgt_q    <= '0;
      post_q    <= '0;
      n_q       <= '0;
      res_m_q   <= '0;
      res_n_q   <= '0;
      res_div_q <= '0;
      res_err_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (in_valid) begin
          ftgt_q <= in_freq;
          post_q <= '0;
          if (in_bad) begin
            res_m_q   <= '0;
            res_n_q   <= '0;
            res_div_q <= '0;
            res_err_q <= 1'b1;
            state_q   <= ST_DONE;
          end else begin
            res_err_q <= 1'b0;
            state_q   <= ST_SCALE;
          end
        end
        ST_SCALE: begin
          if (ftgt_q < FW'(VCO_FLOOR_HZ)) begin
            ftgt_q <= ftgt_q << 1;
            post_q <= post_q + 1'b1;
          end else begin
            n_q     <= NW'(N_FIRST);
            state_q <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          n_q <= n_q + 1'b1;
          if (n_q == NW'(N_LAST)) state_q <= ST_ENCODE;
        end
        ST_ENCODE: begin
          res_m_q   <= enc_m;
          res_n_q   <= enc_n;
          res_div_q <= enc_div;
          state_q   <= ST_DONE;
        end
        ST_DONE: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign out_valid = (state_q == ST_DONE);
  assign out_m     = res_m_q;
  assign out_n     = res_n_q;
  assign out_div   = res_div_q;
  assign out_err   = res_err_q;
endmodule

// File: rtl/pllsrch_checker.sv
`timescale 1ns/1ps
module pllsrch_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_m,
  input logic [7:0] out_n,
  input logic [7:0] out_div,
  input logic       out_err,
  input logic       busy
);
  always_comb begin
    if (!rst_n) assert_reset_idle_R1: assert (!out_valid && in_ready);
  end

  assert_err_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_m == 8'd0 && out_n == 8'd0 && out_div == 8'd0);

  assert_div_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> out_div[3] == 1'b0 && out_div[1:0] == 2'b00 && out_div[7:4] <= 4'd5);

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy && !in_ready);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_m) && $stable(out_n)
      && $stable(out_div) && $stable(out_err));

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);
endmodule

bind dotclk_pll_search pllsrch_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_m(out_m), .out_n(out_n),
  .out_div(out_div), .out_err(out_err), .busy(busy)
);

// File: tb/sim_dotclk_pll_search.sv
`timescale 1ns/1ps
module sim_dotclk_pll_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_freq = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_m, out_n, out_div;
  logic        out_err;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2 clk = ~clk;

  dotclk_pll_search u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_freq(in_freq), .out_valid(out_valid), .out_ready(out_ready),
    .out_m(out_m), .out_n(out_n), .out_div(out_div), .out_err(out_err),
    .busy(busy)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Independent reference of the requirements.
  task automatic model(input longint t, output bit e, output int em, output int en,
                       output int ed, output int k, output bit wide);
    longint f, be, er, mm, mt;
    int bn, bm;
    e = 0; em = 0; en = 0; ed = 0; k = 0; wide = 0;
    if (t > 220000000 || t < 3125000) begin e = 1; return; end
    f = t;
    while (f < 100000000) begin f = f * 2; k++; end
    be = 64'h7fff_ffff_ffff_ffff; bn = 0; bm = 0;
    for (int n = 3; n <= 257; n++) begin
      mm = (f * n) / 14318180;
      if (mm >= 3 && mm <= 257) mt = mm;
      else if (mm > 257 && mm <= 1028) mt = mm & ~64'd3;
      else continue;
      er = f * n - 14318180 * mt;
      if (er < 0) er = -er;
      if (er < be) begin be = er; bn = n; bm = int'(mm); end
    end
    wide = bm > 257;
    em = (wide ? (bm >> 2) : bm) - 2;
    en = bn - 2;
    ed = (k << 4) | (wide ? 0 : 4);
  endtask

  task automatic run(input logic [31:0] f, output int lat);
    @(negedge clk); in_valid = 1'b1; in_freq = f;
    @(posedge clk);
    @(negedge clk); in_valid = 1'b0; lat = 0;
    while (!out_valid && lat < 2000) begin @(posedge clk); @(negedge clk); lat++; end
  endtask

  task automatic req_check(input logic [31:0] f, input string tag);
    int lat, em, en, ed, k; bit e, w;
    model(f, e, em, en, ed, k, w);
    run(f, lat);
    chk({tag, " R2"}, "err", out_err, e);
    chk({tag, " R4"}, "out_n", out_n, en);
    chk({tag, " R7"}, "out_m", out_m, em);
    chk({tag, " R3"}, "out_div", out_div, ed);
    chk({tag, " R8"}, "latency", lat, e ? 0 : k + 257);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "in_ready", in_ready, 1);
  endtask

  task automatic t_legal();
    req_check(32'd25175000, "typical");
    req_check(32'd3125000, "min bound");
    req_check(32'd100000000, "floor exact");
    req_check(32'd220000000, "max bound");
    req_check(32'd65000000, "mid");
  endtask

  task automatic t_reject();
    req_check(32'd220000001, "above max R2");
    req_check(32'd3124999, "below min R2");
    req_check(32'd0, "zero R2");
  endtask

  task automatic t_tie();
    int lat;
    run(32'd100227260, lat);
    chk("R6 tie", "out_m", out_m, 19);
    chk("R6 tie", "out_n", out_n, 1);
    chk("R6 tie", "out_div", out_div, 8'h04);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_wide();
    int em, en, ed, k; bit e, w; longint t;
    bit found = 0;
    for (int i = 0; i < 400 && !found; i++) begin
      t = 100000000 + longint'(i) * 299993;
      model(t, e, em, en, ed, k, w);
      if (w) found = 1;
    end
    chk("R5", "wide target found", found, 1);
    req_check(32'(t), "wide R5");
  endtask

  task automatic t_busy();
    int em, en, ed, k; bit e, w;
    model(48000000, e, em, en, ed, k, w);
    @(negedge clk); in_valid = 1'b1; in_freq = 32'd48000000;
    @(posedge clk);
    @(negedge clk); in_freq = 32'd150000000;
    repeat (20) @(negedge clk);
    chk("R9", "in_ready while busy", in_ready, 0);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    chk("R9", "first result kept out_m", out_m, em);
    chk("R9", "first result kept out_n", out_n, en);
    @(posedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9", "no second result", out_valid, 0);
    end
  endtask

  task automatic t_backpressure();
    int lat; logic [7:0] m0, n0, d0;
    out_ready = 1'b0;
    run(32'd31500000, lat);
    m0 = out_m; n0 = out_n; d0 = out_div;
    repeat (10) @(negedge clk);
    chk("R10", "valid held", out_valid, 1);
    chk("R10", "m held", out_m, m0);
    chk("R10", "n held", out_n, n0);
    chk("R10", "div held", out_div, d0);
    chk("R10", "not ready", in_ready, 0);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R10", "released", out_valid, 0);
    chk("R10", "idle again", in_ready, 1);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_legal();
    t_reject();
    t_tie();
    t_wide();
    t_busy();
    t_backpressure();
    finish_run();
  end
endmodule